// File: doc/BRIEF.md
# System Control Register File

This block is a memory-mapped bank of 32-bit control and status words behind a simple single-cycle slave port. A bus master selects the block, gives a byte address inside a 4 KB window, and either writes a word or reads one back. The port is never stalled: `ready` is always high, a write is stored at the clock edge where it is presented, and read data appears on `rdata` in the cycle after the read is presented.

Besides plain storage, two behaviours are attached to specific addresses. A write to the control word at byte offset 0xF00 is stored like any other write, and the value written can also fire a one-cycle system reset request (values 1 and 2) or a one-cycle power-off request (value 3). Three status words (offsets 0x100, 0x108 and 0x10C) always read back with bits 29 and 28 set, although the stored contents stay as written. After reset, four identification words hold fixed values and every other word holds zero.

The array holds 512 words while the window spans 1024 word slots, so the window holds two images of the array: the word index is taken from address bits 10:2. The control action and the status bit forcing decode the full 12-bit offset, so they act only at their exact offsets and not at the aliases.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, word index 0x40 (offset 0x100) holds 0x05F20121, index 0x41 (offset 0x104) holds 0x00000002, index 0x42 (offset 0x108) holds 0x05F30121, index 0x43 (offset 0x10C) holds 0x05F40121, every other word holds 0, `rdata` is 0 and both request outputs are low.
- R2: A write (`sel`=1, `wr_en`=1) stores `wdata` into the addressed word at that clock edge; a read (`sel`=1, `wr_en`=0) places the addressed word on `rdata` after that edge, one cycle of latency.
- R3: The word index is address bits 10:2; bits 1:0 and every bit above bit 11 are ignored, so offset 0x800+X selects the same word as X, and the exact-offset decodes (control word, forced status words) use address bits 11:2 only.
- R4: A write of 1 or 2 to offset 0xF00 drives `reset_req` high for exactly the one cycle after the write edge.
- R5: A write of 3 to offset 0xF00 drives `shutdown_req` high for exactly the one cycle after the write edge.
- R6: A write of any other value to offset 0xF00, or any write to another offset including the alias 0x700, raises no request; the value written to 0xF00 is still stored and reads back unchanged.
- R7: A read of offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000; the stored word is unchanged, as a read through its alias (offset 0x900, 0x908, 0x90C) shows, and offset 0x104 is not forced.
- R8: `ready` is high in every cycle.
- R9: `rdata` changes only after a read; writes and idle cycles leave it holding the last read value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Access request this cycle |
| wr_en | input | 1 | 1 = write, 0 = read, when `sel` is high |
| addr | input | 32 | Byte address; bits 11:2 decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| ready | output | 1 | Always high, no wait states |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The bench builds the block with its default parameters: 512 words in a 4 KB window, status forcing enabled, control codes 1, 2 and 3. Because the depth is half the window, every word has a second address, which lets the bench read the raw contents of a forced status word and check that a write to the control word's alias stores data without firing a request. High address bits and nonzero low address bits are driven to show they do not change the selected word or the control decode.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned ID_FIRST_IDX = 'h40;
   localparam int unsigned ID_LAST_IDX  = 'h43;

   // Power-on contents of the identification words; all others start at zero.
   function automatic logic [31:0] id_preload(input int unsigned idx);
      logic [31:0] v;
      case (idx)
         'h40:    v = 32'h05F2_0121;
         'h41:    v = 32'h0000_0002;
         'h42:    v = 32'h05F3_0121;
         'h43:    v = 32'h05F4_0121;
         default: v = 32'h0000_0000;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WIN_BYTES = 4096,
   parameter int unsigned DEPTH     = 512,
   parameter int unsigned CTRL_OFF  = 'hF00,
   parameter int unsigned N_FORCE   = 3,
   parameter logic [N_FORCE-1:0][15:0] FORCE_OFFS = {16'h010C, 16'h0108, 16'h0100},
   localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
   localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
   input  logic              sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_fire,
   output logic              rd_fire,
   output logic [IDX_W-1:0]  word_idx,
   output logic              ctrl_hit,
   output logic              force_hit
);

   logic [OFF_W-1:0]   offset;
   logic [N_FORCE-1:0] force_vec;

   // Word aligned offset inside the window: low byte bits dropped (R3).
   assign offset   = {addr[OFF_W-1:2], 2'b00};
   assign word_idx = addr[IDX_W+1:2];
   assign wr_fire  = sel & wr_en;
   assign rd_fire  = sel & ~wr_en;
   assign ctrl_hit = (offset == OFF_W'(CTRL_OFF));

   for (genvar f = 0; f < N_FORCE; f++) begin : g_force_cmp
      assign force_vec[f] = (offset == OFF_W'(FORCE_OFFS[f]));
   end
   assign force_hit = |force_vec;

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 512,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word
);
   import sysctl_pkg::*;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            mem[i] <= DATA_W'(id_preload(i));
         end
      end else if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rd_word = mem[idx];

   // R1: one cycle after reset ends, the first identification word holds its preload
   // unless the first access wrote it.
   p_preload_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (mem[ID_FIRST_IDX] == DATA_W'(id_preload(ID_FIRST_IDX))));

endmodule

// File: rtl/sysctl_req.sv
module sysctl_req #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned RST_CODE0 = 1,
   parameter int unsigned RST_CODE1 = 2,
   parameter int unsigned OFF_CODE  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic              ctrl_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              reset_req,
   output logic              shutdown_req
);

   logic ctrl_wr;
   logic code_rst;
   logic code_off;

   assign ctrl_wr  = wr_fire & ctrl_hit;
   assign code_rst = (wdata == DATA_W'(RST_CODE0)) | (wdata == DATA_W'(RST_CODE1));
   assign code_off = (wdata == DATA_W'(OFF_CODE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_req    <= 1'b0;
         shutdown_req <= 1'b0;
      end else begin
         reset_req    <= ctrl_wr & code_rst;
         shutdown_req <= ctrl_wr & code_off;
      end
   end

   // R5/R4: the two requests never overlap.
   p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reset_req && shutdown_req));

   // R6: no request follows a cycle without a control-word write.
   p_no_req_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> !(reset_req || shutdown_req));

endmodule

// File: rtl/sysctl_rdport.sv
module sysctl_rdport #(
   parameter int unsigned DATA_W     = 32,
   parameter bit          FORCE_EN   = 1'b1,
   parameter logic [31:0] FORCE_MASK = 32'h3000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic              force_hit,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] shaped;

   if (FORCE_EN) begin : g_force
      assign shaped = force_hit ? (rd_word | DATA_W'(FORCE_MASK)) : rd_word;
   end else begin : g_plain
      assign shaped = rd_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_fire) begin
         rdata <= shaped;
      end
   end

   // R9: without a read in the previous cycle, read data holds.
   p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> $stable(rdata));

   // R7: a read of a forced status word returns the mask bits set.
   if (FORCE_EN) begin : g_force_chk
      p_force_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_fire && force_hit) |=> ((rdata & DATA_W'(FORCE_MASK)) == DATA_W'(FORCE_MASK)));
   end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WIN_BYTES  = 4096,
   parameter int unsigned DEPTH      = 512,
   parameter int unsigned CTRL_OFF   = 'hF00,
   parameter int unsigned RST_CODE0  = 1,
   parameter int unsigned RST_CODE1  = 2,
   parameter int unsigned OFF_CODE   = 3,
   parameter bit          FORCE_EN   = 1'b1,
   parameter logic [31:0] FORCE_MASK = 32'h3000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ready,
   output logic              reset_req,
   output logic              shutdown_req
);

   localparam int unsigned OFF_W = $clog2(WIN_BYTES);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   // Elaboration-time parameter checks.
   if (DATA_W < 32) begin : g_bad_width
      $error("sysctl_regfile: DATA_W must be at least 32");
   end
   if ((1 << OFF_W) != WIN_BYTES || (1 << IDX_W) != DEPTH) begin : g_bad_pow2
      $error("sysctl_regfile: WIN_BYTES and DEPTH must be powers of two");
   end
   if (DEPTH * 4 > WIN_BYTES) begin : g_bad_depth
      $error("sysctl_regfile: array larger than the address window");
   end
   if (CTRL_OFF >= WIN_BYTES || (CTRL_OFF % 4) != 0) begin : g_bad_ctrl
      $error("sysctl_regfile: control offset outside window or unaligned");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("sysctl_regfile: address narrower than the window");
   end

   logic             wr_fire;
   logic             rd_fire;
   logic [IDX_W-1:0] word_idx;
   logic             ctrl_hit;
   logic             force_hit;
   logic [DATA_W-1:0] rd_word;

   assign ready = 1'b1;

   sysctl_decode #(
      .ADDR_W    (ADDR_W),
      .WIN_BYTES (WIN_BYTES),
      .DEPTH     (DEPTH),
      .CTRL_OFF  (CTRL_OFF)
   ) u_decode (
      .sel       (sel),
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_fire   (wr_fire),
      .rd_fire   (rd_fire),
      .word_idx  (word_idx),
      .ctrl_hit  (ctrl_hit),
      .force_hit (force_hit)
   );

   sysctl_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_fire),
      .idx     (word_idx),
      .wdata   (wdata),
      .rd_word (rd_word)
   );

   sysctl_req #(
      .DATA_W    (DATA_W),
      .RST_CODE0 (RST_CODE0),
      .RST_CODE1 (RST_CODE1),
      .OFF_CODE  (OFF_CODE)
   ) u_req (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_fire      (wr_fire),
      .ctrl_hit     (ctrl_hit),
      .wdata        (wdata),
      .reset_req    (reset_req),
      .shutdown_req (shutdown_req)
   );

   sysctl_rdport #(
      .DATA_W     (DATA_W),
      .FORCE_EN   (FORCE_EN),
      .FORCE_MASK (FORCE_MASK)
   ) u_rdport (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (rd_fire),
      .force_hit (force_hit),
      .rd_word   (rd_word),
      .rdata     (rdata)
   );

   // R4: a reset request is preceded by a write of a reset code at the control offset.
   p_rst_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(sel && wr_en && (addr[OFF_W-1:2] == (OFF_W-2)'(CTRL_OFF >> 2))
                          && (wdata == DATA_W'(RST_CODE0) || wdata == DATA_W'(RST_CODE1))));

   // R5: a power-off request is preceded by a write of the power-off code there.
   p_off_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> $past(sel && wr_en && (addr[OFF_W-1:2] == (OFF_W-2)'(CTRL_OFF >> 2))
                             && (wdata == DATA_W'(OFF_CODE))));

   // R4: the reset request lasts one cycle per write.
   p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req && !$past(sel && wr_en)) |-> 1'b0);

endmodule

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
module sysctl_regfile_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ready;
   logic        reset_req;
   logic        shutdown_req;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [31:0] last_rd = '0;

   always #2 clk = ~clk;

   sysctl_regfile dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel          (sel),
      .wr_en        (wr_en),
      .addr         (addr),
      .wdata        (wdata),
      .rdata        (rdata),
      .ready        (ready),
      .reset_req    (reset_req),
      .shutdown_req (shutdown_req)
   );

   typedef struct packed {
      logic        wr;
      logic [31:0] a;
      logic [31:0] d;
      logic [31:0] exp;   // expected rdata for reads
      logic        rst;
      logic        shd;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_0100, 32'h0, 32'h35F2_0121, 1'b0, 1'b0, 4'd7}, // R1 R7 forced id word
      '{1'b0, 32'h0000_0104, 32'h0, 32'h0000_0002, 1'b0, 1'b0, 4'd1}, // R1 unforced
      '{1'b0, 32'h0000_0108, 32'h0, 32'h35F3_0121, 1'b0, 1'b0, 4'd7}, // R7
      '{1'b0, 32'h0000_010C, 32'h0, 32'h35F4_0121, 1'b0, 1'b0, 4'd7}, // R7
      '{1'b0, 32'h0000_0900, 32'h0, 32'h05F2_0121, 1'b0, 1'b0, 4'd3}, // R3 alias raw
      '{1'b0, 32'h0000_0000, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 4'd1}, // R1 zero word
      '{1'b1, 32'h0000_0010, 32'hA5A5_0F0F, 32'h0, 1'b0, 1'b0, 4'd2}, // R2 write
      '{1'b0, 32'h0000_0010, 32'h0, 32'hA5A5_0F0F, 1'b0, 1'b0, 4'd2}, // R2 readback
      '{1'b0, 32'hFFFF_F813, 32'h0, 32'hA5A5_0F0F, 1'b0, 1'b0, 4'd3}, // R3 high/low bits ignored
      '{1'b1, 32'h0000_0F00, 32'h1, 32'h0, 1'b1, 1'b0, 4'd4},         // R4 code 1
      '{1'b1, 32'h0000_0F00, 32'h2, 32'h0, 1'b1, 1'b0, 4'd4},         // R4 code 2
      '{1'b1, 32'h0000_0F00, 32'h3, 32'h0, 1'b0, 1'b1, 4'd5},         // R5 code 3
      '{1'b1, 32'h0000_0F00, 32'h4, 32'h0, 1'b0, 1'b0, 4'd6},         // R6 other code
      '{1'b0, 32'h0000_0F00, 32'h0, 32'h0000_0004, 1'b0, 1'b0, 4'd6}, // R6 stored
      '{1'b1, 32'h0000_0700, 32'h1, 32'h0, 1'b0, 1'b0, 4'd6},         // R6 alias no request
      '{1'b0, 32'h0000_0F00, 32'h0, 32'h0000_0001, 1'b0, 1'b0, 4'd6}, // R6 alias stored
      '{1'b1, 32'h0000_0100, 32'h0, 32'h0, 1'b0, 1'b0, 4'd7},         // R7 clear status word
      '{1'b0, 32'h0000_0100, 32'h0, 32'h3000_0000, 1'b0, 1'b0, 4'd7}, // R7 forced bits
      '{1'b0, 32'h0000_0900, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 4'd7}, // R7 stored unchanged
      '{1'b1, 32'h0000_0F02, 32'h3, 32'h0, 1'b0, 1'b1, 4'd3}          // R3 low bits at control
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One access; returns at the negedge after the capturing edge.
   task automatic do_op(input logic wr, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr_en = wr; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state at the ports, R8 ready
      check("R1 rdata after reset", rdata, 32'h0);
      check("R1 reset_req after reset", {31'h0, reset_req}, 32'h0);
      check("R1 shutdown_req after reset", {31'h0, shutdown_req}, 32'h0);
      rst_n = 1'b1;
      check("R8 ready", {31'h0, ready}, 32'h1);

      for (int v = 0; v < NV; v++) begin
         do_op(VECS[v].wr, VECS[v].a, VECS[v].d);
         if (!VECS[v].wr) last_rd = VECS[v].exp;
         // R9: writes leave rdata at the last read value
         check($sformatf("R%0d vec %0d rdata", VECS[v].req, v), rdata, last_rd);
         check($sformatf("R%0d vec %0d reset_req", VECS[v].req, v), {31'h0, reset_req}, {31'h0, VECS[v].rst});
         check($sformatf("R%0d vec %0d shutdown_req", VECS[v].req, v), {31'h0, shutdown_req}, {31'h0, VECS[v].shd});
         check($sformatf("R8 vec %0d ready", v), {31'h0, ready}, 32'h1);
         @(negedge clk);
         // R4 R5: pulses last a single cycle
         check($sformatf("R4 vec %0d pulse end", v), {30'h0, reset_req, shutdown_req}, 32'h0);
         check($sformatf("R9 vec %0d idle hold", v), rdata, last_rd);
      end

      // R4 R5 back-to-back control writes: reset pulse, then power-off pulse
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; addr = 32'hF00; wdata = 32'h1;
      @(negedge clk);
      check("R4 back-to-back reset_req", {31'h0, reset_req}, 32'h1);
      check("R5 back-to-back shutdown_req low", {31'h0, shutdown_req}, 32'h0);
      wdata = 32'h3;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0;
      check("R4 back-to-back reset_req ends", {31'h0, reset_req}, 32'h0);
      check("R5 back-to-back shutdown_req", {31'h0, shutdown_req}, 32'h1);
      @(negedge clk);
      check("R5 back-to-back shutdown ends", {31'h0, shutdown_req}, 32'h0);

      // R1 reset in mid-run restores preload and zeros
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 rdata cleared by reset", rdata, 32'h0);
      rst_n = 1'b1;
      do_op(1'b0, 32'h10, 32'h0);
      check("R1 written word zeroed", rdata, 32'h0);
      do_op(1'b0, 32'h90C, 32'h0);
      check("R1 id word 0x43 preload", rdata, 32'h05F4_0121);
      do_op(1'b0, 32'h100, 32'h0);
      check("R1 id word 0x40 restored", rdata, 32'h35F2_0121);
      do_op(1'b0, 32'hF00, 32'h0);
      check("R1 control word zeroed", rdata, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule